// File: doc/BRIEF.md
# Looping Frame-Buffer DMA Channel Counter

This block keeps the address and count state for one audio DMA channel that cycles through a circular buffer in memory. The buffer is measured in 32-bit longwords. A frame register holds the buffer size and the current longword position. A separate sample register holds a reload value and a running count that sets when a completion event is due. A two-bit byte leftover carries partial longwords from one burst to the next.

A bus master offers a byte count through a burst request. In the same cycle the block returns the clipped burst length and the memory address where the burst starts. If the request is accepted, it then advances the frame position, wraps it at the end of the buffer, and either reloads the sample count with a one-cycle completion pulse or stores the remaining partial count. Software writes the base address, the frame register and the reload half of the sample register through simple write strobes, and reads both count registers back.

Top module: `dma_loop_chan`

## Requirements
- R1: After reset the frame register, the sample register, the base address and the leftover are all zero, and done_o is low.
- R2: A base write loads wdata_i as the buffer base address. A frame write loads the size (bits 15:0) and the current longword index (bits 31:16) from wdata_i, and clears the leftover.
- R3: A sample write changes only the reload half (bits 15:0). The current half (bits 31:16) keeps its value.
- R4: The format shift is fmt_i[0] + fmt_i[1] (bit 0 = stereo, bit 1 = 16-bit). The offered byte count is rounded down to a multiple of 2^shift.
- R5: xfer_bytes_o is the smallest of three values: the rounded offered count, the bytes left in the buffer, and (current + 1) << shift. ack_o is high when burst_req_i is high, the channel is enabled and not paused, and the rounded offered count is nonzero.
- R6: xfer_addr_o equals base + 4 × index + leftover.
- R7: After an accepted burst, the index advances by (moved + leftover) >> 2 and the leftover becomes (moved + leftover) & 3.
- R8: If the advanced index is greater than the size, the index becomes 0. An index equal to the size is kept.
- R9: When moved equals (current + 1) << shift, the current half is loaded from the reload half and done_o is high for exactly the next cycle.
- R10: Otherwise the current half becomes ((current + 1) << shift − moved − 1) >> shift, and done_o stays low.
- R11: While enable_i is low or pause_i is high, ack_o stays low and no count or address state changes.
- R12: The bytes left in the buffer are 4 × (size − index + 1) + leftover when index ≤ size. They are zero when a host write has placed the index beyond the size. An accepted burst in that state moves nothing and returns the index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Channel enable |
| pause_i | input | 1 | Channel pause |
| fmt_i | input | 2 | Sample format: bit 0 stereo, bit 1 16-bit |
| wdata_i | input | 32 | Host write data |
| we_base_i | input | 1 | Write buffer base address |
| we_fcnt_i | input | 1 | Write frame register (index and size) |
| we_scnt_i | input | 1 | Write reload half of the sample register |
| burst_req_i | input | 1 | Bus master offers a burst |
| offered_i | input | 16 | Bytes offered by the bus master |
| ack_o | output | 1 | Burst accepted this cycle |
| xfer_bytes_o | output | 19 | Bytes to move in this burst |
| xfer_addr_o | output | 32 | Start address of the burst |
| done_o | output | 1 | One-cycle completion pulse |
| frame_cnt_o | output | 32 | Frame register: index in 31:16, size in 15:0 |
| samp_cnt_o | output | 32 | Sample register: current in 31:16, reload in 15:0 |

## Verification
The bench drives bursts that leave the leftover at 3. A design that drops the leftover from the address or from the index step would then point one to three bytes off. It also drives a burst that ends exactly on the last longword and one that steps past it: an off-by-one in the wrap compare would either throw away the last longword or run past the end of the buffer. Other cases cover a partial burst against the sample count, checked through the truncating shift, and a current count of zero straight after reset, which must complete at once. An offered count below one sample must be refused. A host write that puts the index beyond the size is also covered: a design that lets the subtraction underflow would report a huge burst there.

// File: rtl/dma_lp_pkg.sv
package dma_lp_pkg;
  // bytes per sample as a left shift: stereo adds one, 16-bit adds one
  function automatic logic [1:0] fmt_shift(input logic [1:0] fmt);
    return {1'b0, fmt[0]} + {1'b0, fmt[1]};
  endfunction
endpackage

// File: rtl/dma_lp_limit.sv
module dma_lp_limit #(
  parameter int HALF_W = 16,
  parameter int CALC_W = HALF_W + 3
) (
  input  logic [HALF_W-1:0] offered_i,
  input  logic [1:0]        shift_i,
  input  logic [CALC_W-1:0] left_i,
  input  logic [CALC_W-1:0] csc_i,
  output logic [CALC_W-1:0] moved_o,
  output logic              nz_o
);
  logic [CALC_W-1:0] off_r, lim_a;

  always_comb begin
    off_r   = CALC_W'(offered_i) & ~((CALC_W'(1) << shift_i) - CALC_W'(1));
    lim_a   = (off_r < left_i) ? off_r : left_i;
    moved_o = (lim_a < csc_i) ? lim_a : csc_i;
    nz_o    = off_r != '0;
  end
endmodule

// File: rtl/dma_lp_frame.sv
module dma_lp_frame #(
  parameter int HALF_W = 16,
  parameter int CALC_W = HALF_W + 3,
  localparam int REG_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_base_i,
  input  logic              we_fcnt_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              acc_i,
  input  logic [CALC_W-1:0] moved_i,
  output logic [CALC_W-1:0] left_o,
  output logic [REG_W-1:0]  addr_o,
  output logic [REG_W-1:0]  fcnt_o
);
  logic [REG_W-1:0]  base_q;
  logic [HALF_W-1:0] size_q, idx_q, idx_nx;
  logic [1:0]        lo_q;
  logic [CALC_W-1:0] sum, nidx_w;

  always_comb begin
    left_o = (idx_q <= size_q)
           ? (((CALC_W'(size_q) - CALC_W'(idx_q)) + CALC_W'(1)) << 2) + CALC_W'(lo_q)
           : '0;
    sum    = moved_i + CALC_W'(lo_q);
    nidx_w = CALC_W'(idx_q) + (sum >> 2);
    idx_nx = (nidx_w > CALC_W'(size_q)) ? '0 : nidx_w[HALF_W-1:0];
    addr_o = base_q + {idx_q, 2'b00} + REG_W'(lo_q);
    fcnt_o = {idx_q, size_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (we_base_i) begin
      base_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q <= '0;
      idx_q  <= '0;
      lo_q   <= '0;
    end else if (we_fcnt_i) begin
      size_q <= wdata_i[HALF_W-1:0];
      idx_q  <= wdata_i[REG_W-1:HALF_W];
      lo_q   <= '0;
    end else if (acc_i) begin
      idx_q  <= idx_nx;
      lo_q   <= sum[1:0];
    end
  end

  // R8
  idx_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !we_fcnt_i) |=> (idx_q <= size_q));

  // R2
  fcnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_fcnt_i |=> (lo_q == 2'd0 && idx_q == $past(wdata_i[REG_W-1:HALF_W])));
endmodule

// File: rtl/dma_lp_sample.sv
module dma_lp_sample #(
  parameter int HALF_W = 16,
  parameter int CALC_W = HALF_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_scnt_i,
  input  logic [HALF_W-1:0] wdata_lo_i,
  input  logic              acc_i,
  input  logic [1:0]        shift_i,
  input  logic [CALC_W-1:0] moved_i,
  output logic [CALC_W-1:0] csc_o,
  output logic [2*HALF_W-1:0] scnt_o,
  output logic              done_o
);
  logic [HALF_W-1:0] rel_q, cur_q, partial;
  logic              fin, done_q;

  always_comb begin
    csc_o   = (CALC_W'(cur_q) + CALC_W'(1)) << shift_i;
    fin     = moved_i == csc_o;
    partial = HALF_W'((csc_o - moved_i - CALC_W'(1)) >> shift_i);
    scnt_o  = {cur_q, rel_q};
    done_o  = done_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_q  <= '0;
      cur_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (we_scnt_i) rel_q <= wdata_lo_i;
      if (acc_i) cur_q <= fin ? rel_q : partial;
      done_q <= acc_i && fin;
    end
  end

  // R9
  done_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cur_q == $past(rel_q)));

  // R9
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(acc_i));
endmodule

// File: rtl/dma_loop_chan.sv
module dma_loop_chan #(
  parameter int HALF_W = 16,
  localparam int REG_W  = 2 * HALF_W,
  localparam int CALC_W = HALF_W + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              pause_i,
  input  logic [1:0]        fmt_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              we_base_i,
  input  logic              we_fcnt_i,
  input  logic              we_scnt_i,
  input  logic              burst_req_i,
  input  logic [HALF_W-1:0] offered_i,
  output logic              ack_o,
  output logic [CALC_W-1:0] xfer_bytes_o,
  output logic [REG_W-1:0]  xfer_addr_o,
  output logic              done_o,
  output logic [REG_W-1:0]  frame_cnt_o,
  output logic [REG_W-1:0]  samp_cnt_o
);
  import dma_lp_pkg::*;

  logic [1:0]        shift;
  logic [CALC_W-1:0] left, csc, moved;
  logic              nz, acc;

  assign shift = fmt_shift(fmt_i);
  assign acc   = burst_req_i && enable_i && !pause_i && nz;
  assign ack_o = acc;
  assign xfer_bytes_o = moved;

  dma_lp_limit #(.HALF_W(HALF_W), .CALC_W(CALC_W)) u_limit (
    .offered_i (offered_i),
    .shift_i   (shift),
    .left_i    (left),
    .csc_i     (csc),
    .moved_o   (moved),
    .nz_o      (nz)
  );

  dma_lp_frame #(.HALF_W(HALF_W), .CALC_W(CALC_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_base_i (we_base_i),
    .we_fcnt_i (we_fcnt_i),
    .wdata_i   (wdata_i),
    .acc_i     (acc),
    .moved_i   (moved),
    .left_o    (left),
    .addr_o    (xfer_addr_o),
    .fcnt_o    (frame_cnt_o)
  );

  dma_lp_sample #(.HALF_W(HALF_W), .CALC_W(CALC_W)) u_sample (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_scnt_i  (we_scnt_i),
    .wdata_lo_i (wdata_i[HALF_W-1:0]),
    .acc_i      (acc),
    .shift_i    (shift),
    .moved_i    (moved),
    .csc_o      (csc),
    .scnt_o     (samp_cnt_o),
    .done_o     (done_o)
  );

  // R11
  no_ack_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i || pause_i) |-> !ack_o);

  // R11
  hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && !we_base_i && !we_fcnt_i && !we_scnt_i)
      |=> ($stable(xfer_addr_o) && $stable(samp_cnt_o)));

  // R5
  bytes_bounded_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (xfer_bytes_o <= CALC_W'(offered_i)));

  // R3
  scnt_hi_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_scnt_i && !ack_o) |=> (samp_cnt_o[REG_W-1:HALF_W] == $past(samp_cnt_o[REG_W-1:HALF_W])));
endmodule

// File: tb/dma_loop_chan_tb.sv
module dma_loop_chan_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0, pause_i = 1'b0;
  logic [1:0]  fmt_i = 2'b00;
  logic [31:0] wdata_i = '0;
  logic        we_base_i = 1'b0, we_fcnt_i = 1'b0, we_scnt_i = 1'b0;
  logic        burst_req_i = 1'b0;
  logic [15:0] offered_i = '0;
  logic        ack_o, done_o;
  logic [18:0] xfer_bytes_o;
  logic [31:0] xfer_addr_o, frame_cnt_o, samp_cnt_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_loop_chan u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .pause_i(pause_i),
    .fmt_i(fmt_i), .wdata_i(wdata_i), .we_base_i(we_base_i),
    .we_fcnt_i(we_fcnt_i), .we_scnt_i(we_scnt_i), .burst_req_i(burst_req_i),
    .offered_i(offered_i), .ack_o(ack_o), .xfer_bytes_o(xfer_bytes_o),
    .xfer_addr_o(xfer_addr_o), .done_o(done_o), .frame_cnt_o(frame_cnt_o),
    .samp_cnt_o(samp_cnt_o)
  );

  typedef struct packed {
    logic [1:0]  fmt;
    logic [15:0] off;
    logic [18:0] bytes;
    logic        ack;
    logic [31:0] addr;
    logic [15:0] cur;
    logic [15:0] idx;
    logic        done;
  } vec_t;

  // start: base 0x1000, size 7, idx 0, leftover 0, cur 0, reload 5
  localparam vec_t VEC [8] = '{
    '{2'b11, 16'd13,  19'd4,  1'b1, 32'h1004, 16'd5, 16'd1, 1'b1}, // R9 cur 0 completes at once
    '{2'b11, 16'd100, 19'd24, 1'b1, 32'h101C, 16'd5, 16'd7, 1'b1}, // R8 lands on last longword
    '{2'b11, 16'd40,  19'd4,  1'b1, 32'h1000, 16'd4, 16'd0, 1'b0}, // R8 wraps, R10 partial
    '{2'b00, 16'd3,   19'd3,  1'b1, 32'h1003, 16'd1, 16'd0, 1'b0}, // R7 leftover 3
    '{2'b01, 16'd7,   19'd4,  1'b1, 32'h1007, 16'd5, 16'd1, 1'b1}, // R4 rounded to 6
    '{2'b10, 16'd1,   19'd0,  1'b0, 32'h1007, 16'd5, 16'd1, 1'b0}, // R4 below one sample
    '{2'b01, 16'd5,   19'd4,  1'b1, 32'h100B, 16'd3, 16'd2, 1'b0}, // R10 shift 1
    '{2'b00, 16'd200, 19'd4,  1'b1, 32'h100F, 16'd5, 16'd3, 1'b1}  // R5 sample-count bound
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_wr(input int which, input logic [31:0] d);
    @(negedge clk);
    wdata_i = d;
    we_base_i = (which == 0);
    we_fcnt_i = (which == 1);
    we_scnt_i = (which == 2);
    @(posedge clk); #1;
    we_base_i = 0; we_fcnt_i = 0; we_scnt_i = 0;
  endtask

  task automatic burst(input logic [1:0] f, input logic [15:0] o,
                       output logic a, output logic [18:0] b);
    @(negedge clk);
    fmt_i = f; offered_i = o; burst_req_i = 1;
    #1;
    a = ack_o; b = xfer_bytes_o;
    @(posedge clk); #1;
    burst_req_i = 0;
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic        a;
    logic [18:0] b;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 frame", frame_cnt_o, 32'h0);
    check("R1 sample", samp_cnt_o, 32'h0);
    check("R1 addr", xfer_addr_o, 32'h0);
    check("R1 done", {31'b0, done_o}, 32'h0);
    @(negedge clk) rst_ni = 1;

    host_wr(0, 32'h0000_1000);
    host_wr(1, 32'h0000_0007);
    host_wr(2, 32'hFFFF_0005);
    check("R3 only reload half written", samp_cnt_o, 32'h0000_0005);
    check("R2 frame load", frame_cnt_o, 32'h0000_0007);
    check("R2/R6 base addr", xfer_addr_o, 32'h0000_1000);
    enable_i = 1;

    for (int i = 0; i < 8; i++) begin
      burst(VEC[i].fmt, VEC[i].off, a, b);
      check("R4/R5 bytes", {13'b0, b}, {13'b0, VEC[i].bytes});
      check("R5 ack", {31'b0, a}, {31'b0, VEC[i].ack});
      check("R6/R7/R8 addr", xfer_addr_o, VEC[i].addr);
      check("R7/R8 index", {16'b0, frame_cnt_o[31:16]}, {16'b0, VEC[i].idx});
      check("R9/R10 current", {16'b0, samp_cnt_o[31:16]}, {16'b0, VEC[i].cur});
      check("R9 done", {31'b0, done_o}, {31'b0, VEC[i].done});
      @(posedge clk); #1;
      check("R9 one-cycle pulse", {31'b0, done_o}, 32'h0);
    end

    // R3 reload write keeps current half (cur 5)
    host_wr(2, 32'hABCD_0009);
    check("R3 current kept", samp_cnt_o, 32'h0005_0009);

    // R2 frame write clears leftover
    host_wr(1, 32'h0002_000F);
    check("R2 frame readback", frame_cnt_o, 32'h0002_000F);
    check("R2 leftover cleared", xfer_addr_o, 32'h0000_1008);

    // R11 disabled
    enable_i = 0;
    burst(2'b11, 16'd8, a, b);
    check("R11 no ack disabled", {31'b0, a}, 32'h0);
    check("R11 addr held", xfer_addr_o, 32'h0000_1008);
    check("R11 sample held", samp_cnt_o, 32'h0005_0009);
    // R11 paused
    enable_i = 1; pause_i = 1;
    burst(2'b11, 16'd8, a, b);
    check("R11 no ack paused", {31'b0, a}, 32'h0);
    check("R11 frame held", frame_cnt_o, 32'h0002_000F);
    pause_i = 0;

    // R8 index equal to size is kept
    host_wr(1, 32'h0002_0003);
    burst(2'b11, 16'd4, a, b);
    check("R8 bytes", {13'b0, b}, 32'd4);
    check("R8 no wrap at size", frame_cnt_o, 32'h0003_0003);
    check("R10 partial", samp_cnt_o, 32'h0004_0009);

    // R12 index beyond size
    host_wr(1, 32'h0005_0003);
    burst(2'b11, 16'd8, a, b);
    check("R12 ack", {31'b0, a}, 32'h1);
    check("R12 zero bytes", {13'b0, b}, 32'h0);
    check("R12 index to 0", frame_cnt_o, 32'h0000_0003);
    check("R12 addr", xfer_addr_o, 32'h0000_1000);
    check("R12 current kept", samp_cnt_o, 32'h0004_0009);

    finished = 1;
    summary();
    $finish;
  end
endmodule